// File: doc/BRIEF.md
# Memory Rank Power State Manager

This block chooses the power state of each memory rank in a small memory subsystem. It sits between the request front end and the ranks. It sends each rank a state code and raises a per-rank grant once that rank can take an access. The block has no part in command timing, data movement or refresh. It only decides whether a rank sleeps, wakes or stays ready.

Four policies are available. In the ownership policy, the ranks named in the running process's mask stay ready and every other rank sleeps. A context-switch strobe loads a new mask and starts waking the newly owned ranks in the strobe cycle itself. This hides the wake time before that process's first access. The three on-demand policies ignore the mask. Each one wakes a rank only for a pending access and puts it back to sleep in the cycle its completion is reported, with no idle timer. The three differ only in sleep depth: a shallow power-down with a short wake, a self-refresh with a long wake, or fully off (for a non-volatile rank) with the same long wake. Wake times are parameters counted in clock cycles.

Top module: `rank_pwr_mgr`

## Requirements
- R1: After reset every rank reports state code 1 (self-refresh), no grant is raised and the ownership mask is empty. The state codes are 0 power-down, 1 self-refresh, 2 off, 3 waking and 4 ready. Rank i's code sits at rank_state_o[3i+2:3i].
- R2: With policy 0 (ownership), a rank whose mask bit is set stays in state 4 once it is ready, even after its accesses complete. A rank whose mask bit is clear sleeps in state 1.
- R3: In the cycle of a context-switch strobe, the strobe's mask takes effect. After that edge, newly owned sleeping ranks are in state 3 and ranks that are no longer owned go to sleep. A request to an owned ready rank is granted in the next cycle.
- R4: A request (req_valid_i with req_rank_i) to a sleeping rank moves it to state 3. Its grant appears exactly W+1 clock edges after the request edge, where W is the wake time for the state the rank slept in.
- R5: In an on-demand policy, a done pulse for a busy rank with no further request returns that rank to its sleep state at that same edge.
- R6: The sleep state follows the policy: policy 1 gives state 0 with wake SHORT_WAKE, policy 2 gives state 1 and policy 3 gives state 2. States 1 and 2 both wake in LONG_WAKE. On-demand policies ignore the mask.
- R7: A rank that is ready, or that wakes quickly, is granted while another rank is still waking.
- R8: A repeated request to a rank that is already waking is held and does not restart its wake, so the grant time is unchanged.
- R9: A grant is a single-cycle pulse. A rank gives no second grant until its access is reported done.
- R10: When a done pulse and a new request for the same rank fall in one cycle, the rank stays in state 4 and grants again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | 0 ownership, 1 shallow on-demand, 2 deep on-demand, 3 off on-demand |
| req_valid_i | input | 1 | Access request strobe |
| req_rank_i | input | RANK_W | Target rank of the request |
| done_valid_i | input | 1 | Access completion strobe |
| done_rank_i | input | RANK_W | Rank whose access completed |
| ctx_switch_i | input | 1 | Context-switch strobe |
| ctx_mask_i | input | NUM_RANKS | Ranks owned by the incoming process |
| rank_state_o | output | 3*NUM_RANKS | Per-rank state code |
| grant_o | output | NUM_RANKS | Per-rank grant pulse |

## Verification
Two kinds of event can land in the same cycle. The first is a completion and a fresh request for one rank. The bench waits until the rank is busy and then drives both strobes on one clock. It then expects the rank to stay ready and grant on the next edge, without passing through a sleep state. The second is a grant on one rank during another rank's wake. A cycle-by-cycle loop interleaves a long-wake request, a short-wake request and a repeated request. At every edge it compares both grant bits against the cycle counts computed from the two wake times.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  typedef enum logic [1:0] {
    POL_OWNER = 2'd0,
    POL_SHALLOW = 2'd1,
    POL_DEEP = 2'd2,
    POL_OFF = 2'd3
  } pol_e;

  typedef enum logic [2:0] {
    RS_PDN   = 3'd0,
    RS_SREF  = 3'd1,
    RS_OFF   = 3'd2,
    RS_WAKE  = 3'd3,
    RS_READY = 3'd4
  } rstate_e;

  localparam int STATE_W = 3;

  function automatic rstate_e sleep_for(input pol_e pol);
    case (pol)
      POL_SHALLOW: sleep_for = RS_PDN;
      POL_OFF:     sleep_for = RS_OFF;
      default:     sleep_for = RS_SREF;
    endcase
  endfunction

  function automatic logic is_low(input rstate_e st);
    is_low = (st == RS_PDN) || (st == RS_SREF) || (st == RS_OFF);
  endfunction

endpackage

// File: rtl/ctx_mask_reg.sv
module ctx_mask_reg #(
  parameter int NUM_RANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctx_switch_i,
  input  logic [NUM_RANKS-1:0] ctx_mask_i,
  output logic [NUM_RANKS-1:0] eff_mask_o
);

  logic [NUM_RANKS-1:0] mask_q;
  logic [NUM_RANKS-1:0] mask_n;
  logic                 mask_en;

  always_comb begin
    mask_en = ctx_switch_i;
    mask_n  = ctx_mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_n;
    end
  end

  // The strobe's mask is effective in its own cycle, so wakes start at once.
  assign eff_mask_o = ctx_switch_i ? ctx_mask_i : mask_q;

endmodule

// File: rtl/rank_fsm.sv
module rank_fsm
  import rpm_pkg::*;
#(
  parameter int SHORT_WAKE = 2,
  parameter int LONG_WAKE  = 15,
  parameter int CNT_W      = $clog2(LONG_WAKE + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pol_e         policy_i,
  input  logic         owned_i,
  input  logic         req_hit_i,
  input  logic         done_hit_i,
  output rstate_e      state_o,
  output logic         grant_o
);

  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAKE - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAKE - 1);

  rstate_e          state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             pend_q, pend_n;
  logic             busy_q, busy_n;
  logic             want;

  assign grant_o = (state_q == RS_READY) && pend_q && !busy_q;
  assign state_o = state_q;

  always_comb begin
    want    = owned_i | pend_q | (busy_q & ~done_hit_i) | req_hit_i;
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    pend_n  = (pend_q & ~grant_o) | req_hit_i;
    busy_n  = grant_o ? 1'b1 : (busy_q & ~done_hit_i);
    case (state_q)
      RS_READY: begin
        if (!want) state_n = sleep_for(policy_i);
      end
      RS_WAKE: begin
        if (cnt_q == '0) begin
          state_n = RS_READY;
        end else begin
          cnt_en = 1'b1;
          cnt_n  = cnt_q - 1'b1;
        end
      end
      default: begin
        if (want) begin
          state_n = RS_WAKE;
          cnt_en  = 1'b1;
          cnt_n   = (state_q == RS_PDN) ? SHORT_LD : LONG_LD;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_SREF;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      busy_q  <= busy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  // R2
  owned_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_i && state_q == RS_READY) |=> (state_q == RS_READY));

  // R3
  owned_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_i && is_low(state_q)) |=> (state_q == RS_WAKE));

  // R4
  no_skip_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_low(state_q) |=> (is_low(state_q) || state_q == RS_WAKE));

  // R5
  sleep_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_READY && busy_q && done_hit_i && !req_hit_i && !pend_q && !owned_i)
    |=> is_low(state_q));

  // R8
  wake_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_WAKE && cnt_q != '0) |=>
    (state_q == RS_WAKE && cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);

endmodule

// File: rtl/rank_pwr_mgr.sv
module rank_pwr_mgr
  import rpm_pkg::*;
#(
  parameter int NUM_RANKS  = 3,
  parameter int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  parameter int SHORT_WAKE = 2,
  parameter int LONG_WAKE  = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     policy_i,
  input  logic                           req_valid_i,
  input  logic [RANK_W-1:0]              req_rank_i,
  input  logic                           done_valid_i,
  input  logic [RANK_W-1:0]              done_rank_i,
  input  logic                           ctx_switch_i,
  input  logic [NUM_RANKS-1:0]           ctx_mask_i,
  output logic [STATE_W*NUM_RANKS-1:0]   rank_state_o,
  output logic [NUM_RANKS-1:0]           grant_o
);

  pol_e                 pol;
  logic [NUM_RANKS-1:0] eff_mask;

  assign pol = pol_e'(policy_i);

  ctx_mask_reg #(.NUM_RANKS(NUM_RANKS)) u_mask (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctx_switch_i (ctx_switch_i),
    .ctx_mask_i   (ctx_mask_i),
    .eff_mask_o   (eff_mask)
  );

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
    logic    req_hit, done_hit, owned;
    rstate_e st;

    assign req_hit  = req_valid_i  && (req_rank_i  == RANK_W'(i));
    assign done_hit = done_valid_i && (done_rank_i == RANK_W'(i));
    assign owned    = (pol == POL_OWNER) && eff_mask[i];

    rank_fsm #(
      .SHORT_WAKE (SHORT_WAKE),
      .LONG_WAKE  (LONG_WAKE)
    ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .policy_i   (pol),
      .owned_i    (owned),
      .req_hit_i  (req_hit),
      .done_hit_i (done_hit),
      .state_o    (st),
      .grant_o    (grant_o[i])
    );

    assign rank_state_o[STATE_W*i +: STATE_W] = st;
  end

endmodule

// File: tb/rank_pwr_mgr_test.sv
module rank_pwr_mgr_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int RW = 2;
  localparam int SW = 2;
  localparam int LW = 15;

  logic          clk;
  logic          rst_n;
  logic [1:0]    policy;
  logic          req_valid;
  logic [RW-1:0] req_rank;
  logic          done_valid;
  logic [RW-1:0] done_rank;
  logic          ctx_sw;
  logic [N-1:0]  ctx_mask;
  logic [3*N-1:0] rank_state;
  logic [N-1:0]  grant;

  int checks;
  int failures;
  bit finished;

  rank_pwr_mgr #(
    .NUM_RANKS(N), .RANK_W(RW), .SHORT_WAKE(SW), .LONG_WAKE(LW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy),
    .req_valid_i(req_valid), .req_rank_i(req_rank),
    .done_valid_i(done_valid), .done_rank_i(done_rank),
    .ctx_switch_i(ctx_sw), .ctx_mask_i(ctx_mask),
    .rank_state_o(rank_state), .grant_o(grant)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int st(input int r);
    return int'(rank_state[3*r +: 3]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input int r);
    req_valid = 1'b1; req_rank = RW'(r);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_done(input int r);
    done_valid = 1'b1; done_rank = RW'(r);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int r = 0; r < N; r++) chk("R1 reset state", st(r), 1);
    chk("R1 no grant", int'(grant), 0);
  endtask

  task automatic t_shallow;
    policy = 2'd1;
    pulse_req(0);
    edges(LW - 1);
    chk("R4 still waking", st(0), 3);
    chk("R4 no early grant", int'(grant[0]), 0);
    edges(1);
    chk("R4 grant after long wake", int'(grant[0]), 1);
    edges(1);
    chk("R9 grant single pulse", int'(grant[0]), 0);
    chk("R9 ready while busy", st(0), 4);
    pulse_done(0);
    chk("R5 R6 sleeps in power-down", st(0), 0);
    pulse_req(0);
    edges(SW - 1);
    chk("R6 short wake no early grant", int'(grant[0]), 0);
    edges(1);
    chk("R6 short wake grant", int'(grant[0]), 1);
    edges(1);
    pulse_done(0);
    chk("R5 back to power-down", st(0), 0);
  endtask

  task automatic t_overlap;
    policy = 2'd2;
    for (int c = 0; c <= LW + 2; c++) begin
      req_valid = (c == 0) || (c == 1) || (c == 5);
      req_rank  = (c == 1) ? RW'(0) : RW'(1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 rank1 grant timing", int'(grant[1]), int'(c == LW));
      chk("R7 rank0 grant during rank1 wake", int'(grant[0]), int'(c == 1 + SW));
    end
    pulse_done(0);
    pulse_done(1);
    chk("R6 deep sleep rank0", st(0), 1);
    chk("R6 deep sleep rank1", st(1), 1);
  endtask

  task automatic t_owner;
    policy = 2'd0; ctx_sw = 1'b1; ctx_mask = 3'b101;
    @(negedge clk);
    ctx_sw = 1'b0;
    chk("R3 owned rank0 waking", st(0), 3);
    chk("R3 owned rank2 waking", st(2), 3);
    chk("R2 unowned rank1 asleep", st(1), 1);
    edges(LW);
    chk("R2 rank0 ready", st(0), 4);
    chk("R2 rank2 ready", st(2), 4);
    chk("R2 rank1 still asleep", st(1), 1);
    pulse_req(0);
    chk("R3 no wake delay grant", int'(grant[0]), 1);
    edges(1);
    pulse_done(0);
    chk("R2 owned stays ready after done", st(0), 4);
    ctx_sw = 1'b1; ctx_mask = 3'b010;
    @(negedge clk);
    ctx_sw = 1'b0;
    chk("R3 dropped rank0 sleeps", st(0), 1);
    chk("R3 dropped rank2 sleeps", st(2), 1);
    chk("R3 new rank1 waking", st(1), 3);
    edges(LW);
    chk("R2 rank1 ready", st(1), 4);
  endtask

  task automatic t_off;
    policy = 2'd3;
    edges(1);
    chk("R6 mask ignored, rank1 off", st(1), 2);
    pulse_req(2);
    edges(LW - 1);
    chk("R4 rank2 no early grant", int'(grant[2]), 0);
    edges(1);
    chk("R4 rank2 grant", int'(grant[2]), 1);
    edges(1);
    done_valid = 1'b1; done_rank = RW'(2);
    req_valid  = 1'b1; req_rank  = RW'(2);
    @(negedge clk);
    done_valid = 1'b0; req_valid = 1'b0;
    chk("R10 stays ready", st(2), 4);
    chk("R10 regrant", int'(grant[2]), 1);
    edges(1);
    pulse_done(2);
    chk("R6 rank2 off", st(2), 2);
    pulse_req(2);
    edges(LW - 1);
    chk("R6 off wake no early grant", int'(grant[2]), 0);
    edges(1);
    chk("R6 off wake grant", int'(grant[2]), 1);
    edges(1);
    pulse_done(2);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    rst_n = 1'b0; policy = 2'd0;
    req_valid = 1'b0; req_rank = '0;
    done_valid = 1'b0; done_rank = '0;
    ctx_sw = 1'b0; ctx_mask = '0;
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_shallow();
    t_overlap();
    t_owner();
    t_off();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule